// File: doc/BRIEF.md
# Machine State Register Write Unit

This block owns a 64-bit machine state register and applies the rules that govern every write to it. A write word passes through an implementation mask, the hypervisor bit is protected against unprivileged change, and on 64-bit segmented implementations entering problem state forces three enable bits on. From the new register value the block derives two 3-bit translation-mode indices (one for instruction fetch, one for data access) and a hidden-flags word. It also emits single-cycle side-effect strobes: a translation-cache flush request, a shadow-register swap enable, an exception-vector base update and a halt event.

Writes arrive on a valid/ready port. The unit always accepts (`wr_ready` is tied high), so the upstream never sees back-pressure, and a word is taken on every clock edge where `wr_valid` is high. All derived outputs are registered and change on the same edge that updates the register, so they are valid in the cycle that follows the write. Bit positions, the write mask, the reset value and three configuration switches (embedded-style translation, 64-bit segmented, shadow registers present) are parameters.

Top module: `msr_write_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the register loads RESET_VAL (default 0x9000_0000_0000_0000), `halt` and all strobes go low, the indices and hidden flags follow RESET_VAL, and `excp_base` reflects RESET_VAL's prefix bit.
- R2: A written word is ANDed with WMASK (default: all bits except 1 and 2) before any other rule applies.
- R3: The hypervisor bit (60) takes the written value only if `wr_alter_hv` is high and the current bit 60 is already 1; otherwise it keeps its old value.
- R4: With SEG64 set, a write that leaves problem state (bit 14) at 1 also sets bits 15, 5 and 4; with SEG64 clear no bit is forced.
- R5: `flush_req` pulses after a write that changes bit 5 or bit 4; with EMBEDDED_MMU set, a change of the guest-state bit 28 also pulses it.
- R6: With SHADOW_EN set, `swap_req` pulses after a write that toggles bit 17; with SHADOW_EN clear it never pulses.
- R7: A write that changes the prefix bit 6 pulses `prefix_we` and sets `excp_base` to 0xFFF00000 when bit 6 is 1, or to 0 when it is 0.
- R8: In server mode each index is {bit 60, NOT relocate, NOT bit 14}, relocate being bit 5 for `immu_idx` and bit 4 for `dmmu_idx`.
- R9: In embedded mode each index is {bit 28, space bit, NOT bit 14}, the space bit being bit 5 for `immu_idx` and bit 4 for `dmmu_idx`.
- R10: `hflags` equals the register value ANDed with bits {63, 60, 31, 25, 23, 14, 13, 10, 9, 5, 4, 0}, ORed with `nmsr_flags` as sampled on the same edge; register bits 11 and 8 never reach it.
- R11: A write leaving power-save bit 18 at 1 while `irq_pending` is low and `pow_ok` high sets `halt` and pulses `halt_evt`.
- R12: `halt` clears on the edge after `irq_pending` is seen high.
- R13: Every strobe is high for exactly one cycle after a write and low after any edge without a write.
- R14: `wr_ready` is always 1; with `wr_valid` low the register, indices and `excp_base` do not change whatever `wr_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Write word present |
| wr_ready | output | 1 | Always 1, the unit never stalls |
| wr_data | input | 64 | Requested register value |
| wr_alter_hv | input | 1 | Write is a privileged hypervisor-altering write |
| nmsr_flags | input | 64 | Flags from other registers merged into `hflags` |
| irq_pending | input | 1 | An interrupt is pending |
| pow_ok | input | 1 | External power-save permission |
| msr_q | output | 64 | Current register value |
| immu_idx | output | 3 | Instruction-side translation-mode index |
| dmmu_idx | output | 3 | Data-side translation-mode index |
| hflags | output | 64 | Hidden-flags word |
| flush_req | output | 1 | Translation-cache flush pulse |
| swap_req | output | 1 | Shadow/general register swap pulse |
| prefix_we | output | 1 | Exception base update pulse |
| excp_base | output | 32 | Exception vector base |
| halt | output | 1 | Halted status |
| halt_evt | output | 1 | Halt entry pulse |

## Verification
The bench drives a server-style and an embedded-style instance side by side with the same writes, so a design that mixed the two index encodings or let the guest-state bit flush in server mode shows a mismatch on one of them. It attempts to clear and set the hypervisor bit with and without privilege after the bit has been dropped, which a design that only looked at `wr_alter_hv` would get wrong. Problem-state writes with the enables clear catch a missing or unconditional forcing rule, and the idle cycle after each write catches strobes that stay high or registers that follow `wr_data` without `wr_valid`. Power-save writes with an interrupt pending, and interrupts arriving while halted, catch halt logic that ignores the pending line.

// File: rtl/msr_wu_pkg.sv
package msr_wu_pkg;

  localparam int VEC_W = 32;
  localparam logic [VEC_W-1:0] HIGH_VEC = 32'hFFF0_0000;

  typedef struct packed {
    logic flush;
    logic swap;
    logic prefix;
    logic halt_go;
  } msr_evt_t;

  function automatic logic [VEC_W-1:0] vec_base(input logic ep);
    return ep ? HIGH_VEC : '0;
  endfunction

endpackage

// File: rtl/msr_sanitize.sv
module msr_sanitize #(
  parameter int XLEN = 64,
  parameter logic [XLEN-1:0] WMASK = '1,
  parameter int HV_POS = 60,
  parameter int PR_POS = 14,
  parameter int EE_POS = 15,
  parameter int IR_POS = 5,
  parameter int DR_POS = 4,
  parameter bit SEG64 = 1'b1
) (
  input  logic [XLEN-1:0] req_val,
  input  logic            alter_hv,
  input  logic [XLEN-1:0] cur_val,
  output logic [XLEN-1:0] new_val
);

  localparam logic [XLEN-1:0] FORCE_SET =
    (XLEN'(1) << EE_POS) | (XLEN'(1) << IR_POS) | (XLEN'(1) << DR_POS);

  logic [XLEN-1:0] masked;
  logic [XLEN-1:0] hv_fixed;
  logic            hv_may_change;

  always_comb begin
    masked        = req_val & WMASK;
    hv_may_change = alter_hv & cur_val[HV_POS];
    hv_fixed      = masked;
    hv_fixed[HV_POS] = hv_may_change ? masked[HV_POS] : cur_val[HV_POS];
  end

  generate
    if (SEG64) begin : g_force
      assign new_val = hv_fixed[PR_POS] ? (hv_fixed | FORCE_SET) : hv_fixed;
    end else begin : g_plain
      assign new_val = hv_fixed;
    end
  endgenerate

endmodule

// File: rtl/msr_mode_index.sv
module msr_mode_index #(
  parameter bit INVERT_MID = 1'b1
) (
  input  logic       pr,
  input  logic       i_mid,
  input  logic       d_mid,
  input  logic       top,
  output logic [2:0] i_idx,
  output logic [2:0] d_idx
);

  logic i_b1, d_b1;

  generate
    if (INVERT_MID) begin : g_server
      assign i_b1 = ~i_mid;
      assign d_b1 = ~d_mid;
    end else begin : g_embedded
      assign i_b1 = i_mid;
      assign d_b1 = d_mid;
    end
  endgenerate

  assign i_idx = {top, i_b1, ~pr};
  assign d_idx = {top, d_b1, ~pr};

endmodule

// File: rtl/msr_event_detect.sv
module msr_event_detect
  import msr_wu_pkg::*;
#(
  parameter bit EMBEDDED_MMU = 1'b0,
  parameter bit SHADOW_EN = 1'b1
) (
  input  logic     fire,
  input  logic     d_ir,
  input  logic     d_dr,
  input  logic     d_gs,
  input  logic     d_tgpr,
  input  logic     d_ep,
  input  logic     n_pow,
  input  logic     irq_pending,
  input  logic     pow_ok,
  output msr_evt_t evt
);

  localparam logic GS_COUNTS = EMBEDDED_MMU;
  localparam logic SWAP_ON   = SHADOW_EN;

  always_comb begin
    evt.flush   = fire & (d_ir | d_dr | (GS_COUNTS & d_gs));
    evt.swap    = fire & SWAP_ON & d_tgpr;
    evt.prefix  = fire & d_ep;
    evt.halt_go = fire & n_pow & ~irq_pending & pow_ok;
  end

endmodule

// File: rtl/msr_write_unit.sv
module msr_write_unit
  import msr_wu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter logic [XLEN-1:0] WMASK     = ~64'h6,
  parameter logic [XLEN-1:0] RESET_VAL = 64'h9000_0000_0000_0000,
  parameter bit EMBEDDED_MMU = 1'b0,
  parameter bit SEG64        = 1'b1,
  parameter bit SHADOW_EN    = 1'b1,
  parameter int SF_POS   = 63,
  parameter int HV_POS   = 60,
  parameter int CM_POS   = 31,
  parameter int GS_POS   = 28,
  parameter int VR_POS   = 25,
  parameter int VSX_POS  = 23,
  parameter int POW_POS  = 18,
  parameter int TGPR_POS = 17,
  parameter int EE_POS   = 15,
  parameter int PR_POS   = 14,
  parameter int FP_POS   = 13,
  parameter int SE_POS   = 10,
  parameter int BE_POS   = 9,
  parameter int EP_POS   = 6,
  parameter int IR_POS   = 5,
  parameter int DR_POS   = 4,
  parameter int IS_POS   = 5,
  parameter int DS_POS   = 4,
  parameter int LE_POS   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             wr_alter_hv,
  input  logic [XLEN-1:0]  nmsr_flags,
  input  logic             irq_pending,
  input  logic             pow_ok,
  output logic [XLEN-1:0]  msr_q,
  output logic [2:0]       immu_idx,
  output logic [2:0]       dmmu_idx,
  output logic [XLEN-1:0]  hflags,
  output logic             flush_req,
  output logic             swap_req,
  output logic             prefix_we,
  output logic [VEC_W-1:0] excp_base,
  output logic             halt,
  output logic             halt_evt
);

  localparam int I_MID_POS = EMBEDDED_MMU ? IS_POS : IR_POS;
  localparam int D_MID_POS = EMBEDDED_MMU ? DS_POS : DR_POS;
  localparam int TOP_POS   = EMBEDDED_MMU ? GS_POS : HV_POS;
  localparam logic [XLEN-1:0] HMASK =
    (XLEN'(1) << SF_POS) | (XLEN'(1) << HV_POS) | (XLEN'(1) << CM_POS) |
    (XLEN'(1) << VR_POS) | (XLEN'(1) << VSX_POS) | (XLEN'(1) << PR_POS) |
    (XLEN'(1) << FP_POS) | (XLEN'(1) << SE_POS) | (XLEN'(1) << BE_POS) |
    (XLEN'(1) << IR_POS) | (XLEN'(1) << DR_POS) | (XLEN'(1) << LE_POS);

  logic [XLEN-1:0] san_val;
  logic [XLEN-1:0] msr_d;
  logic [XLEN-1:0] diff;
  logic [XLEN-1:0] hflags_d;
  logic [2:0]      i_idx_d, d_idx_d;
  msr_evt_t        evt;

  assign wr_ready = 1'b1;

  // write sanitising: mask, hypervisor lock, problem-state forcing
  msr_sanitize #(
    .XLEN(XLEN), .WMASK(WMASK), .HV_POS(HV_POS), .PR_POS(PR_POS),
    .EE_POS(EE_POS), .IR_POS(IR_POS), .DR_POS(DR_POS), .SEG64(SEG64)
  ) u_san (
    .req_val (wr_data),
    .alter_hv(wr_alter_hv),
    .cur_val (msr_q),
    .new_val (san_val)
  );

  assign msr_d = !rst_n ? RESET_VAL : (wr_valid ? san_val : msr_q);
  assign diff  = msr_q ^ san_val;

  msr_event_detect #(
    .EMBEDDED_MMU(EMBEDDED_MMU), .SHADOW_EN(SHADOW_EN)
  ) u_evt (
    .fire       (wr_valid & rst_n),
    .d_ir       (diff[IR_POS]),
    .d_dr       (diff[DR_POS]),
    .d_gs       (diff[GS_POS]),
    .d_tgpr     (diff[TGPR_POS]),
    .d_ep       (diff[EP_POS]),
    .n_pow      (san_val[POW_POS]),
    .irq_pending(irq_pending),
    .pow_ok     (pow_ok),
    .evt        (evt)
  );

  msr_mode_index #(.INVERT_MID(!EMBEDDED_MMU)) u_idx (
    .pr   (msr_d[PR_POS]),
    .i_mid(msr_d[I_MID_POS]),
    .d_mid(msr_d[D_MID_POS]),
    .top  (msr_d[TOP_POS]),
    .i_idx(i_idx_d),
    .d_idx(d_idx_d)
  );

  assign hflags_d = (msr_d & HMASK) | (rst_n ? nmsr_flags : '0);

  always_ff @(posedge clk) begin
    msr_q    <= msr_d;
    immu_idx <= i_idx_d;
    dmmu_idx <= d_idx_d;
    hflags   <= hflags_d;
    if (!rst_n) begin
      flush_req <= 1'b0;
      swap_req  <= 1'b0;
      prefix_we <= 1'b0;
      halt_evt  <= 1'b0;
      halt      <= 1'b0;
      excp_base <= vec_base(RESET_VAL[EP_POS]);
    end else begin
      flush_req <= evt.flush;
      swap_req  <= evt.swap;
      prefix_we <= evt.prefix;
      halt_evt  <= evt.halt_go;
      if (evt.prefix) excp_base <= vec_base(san_val[EP_POS]);
      if (evt.halt_go)      halt <= 1'b1;
      else if (irq_pending) halt <= 1'b0;
    end
  end

  // R3: hypervisor bit only moves on a privileged write while already set
  a_r3_hv_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !(wr_alter_hv && msr_q[HV_POS])) |=> msr_q[HV_POS] == $past(msr_q[HV_POS]));

  generate
    if (SEG64) begin : g_a_force
      // R4: problem state pulls the enables on
      a_r4_pr_forces: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_data[PR_POS] && WMASK[PR_POS]) |=>
          (msr_q[EE_POS] && msr_q[IR_POS] && msr_q[DR_POS]));
    end
  endgenerate

  // R7: base always matches the prefix bit when updated
  a_r7_prefix_base: assert property (@(posedge clk) disable iff (!rst_n)
    prefix_we |-> excp_base == vec_base(msr_q[EP_POS]));

  // R11: a halt event always leaves the unit halted
  a_r11_evt_halts: assert property (@(posedge clk) disable iff (!rst_n)
    halt_evt |-> halt);

  // R12: pending interrupt releases halt
  a_r12_irq_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |=> !halt);

  // R13: no strobe without a write
  a_r13_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !(flush_req || swap_req || prefix_we || halt_evt));

  // R14: register holds when nothing is written
  a_r14_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> msr_q == $past(msr_q));

endmodule

// File: tb/tb_msr_write_unit.sv
module tb_msr_write_unit;

  localparam logic [63:0] WM   = ~64'h6;
  localparam logic [63:0] RSTV = 64'h9000_0000_0000_0000;
  localparam logic [63:0] HM   = (64'd1 << 63) | (64'd1 << 60) | (64'd1 << 31) |
    (64'd1 << 25) | (64'd1 << 23) | (64'd1 << 14) | (64'd1 << 13) |
    (64'd1 << 10) | (64'd1 << 9) | (64'd1 << 5) | (64'd1 << 4) | 64'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [63:0] wr_data = '0;
  logic wr_alter_hv = 1'b0;
  logic [63:0] nmsr_flags = '0;
  logic irq_pending = 1'b0;
  logic pow_ok = 1'b0;

  logic        rdy[2];
  logic [63:0] o_msr[2], o_hf[2];
  logic [2:0]  o_ii[2], o_di[2];
  logic        o_fl[2], o_sw[2], o_pw[2], o_h[2], o_he[2];
  logic [31:0] o_base[2];

  always #10 clk = ~clk;

  msr_write_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(rdy[0]),
    .wr_data(wr_data), .wr_alter_hv(wr_alter_hv), .nmsr_flags(nmsr_flags),
    .irq_pending(irq_pending), .pow_ok(pow_ok), .msr_q(o_msr[0]),
    .immu_idx(o_ii[0]), .dmmu_idx(o_di[0]), .hflags(o_hf[0]),
    .flush_req(o_fl[0]), .swap_req(o_sw[0]), .prefix_we(o_pw[0]),
    .excp_base(o_base[0]), .halt(o_h[0]), .halt_evt(o_he[0])
  );

  msr_write_unit #(.EMBEDDED_MMU(1'b1), .SEG64(1'b0), .SHADOW_EN(1'b0)) dut_e (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(rdy[1]),
    .wr_data(wr_data), .wr_alter_hv(wr_alter_hv), .nmsr_flags(nmsr_flags),
    .irq_pending(irq_pending), .pow_ok(pow_ok), .msr_q(o_msr[1]),
    .immu_idx(o_ii[1]), .dmmu_idx(o_di[1]), .hflags(o_hf[1]),
    .flush_req(o_fl[1]), .swap_req(o_sw[1]), .prefix_we(o_pw[1]),
    .excp_base(o_base[1]), .halt(o_h[1]), .halt_evt(o_he[1])
  );

  typedef struct {
    string       tag;
    logic [63:0] msr [2];
    logic [63:0] hf  [2];
    logic [31:0] base[2];
    logic [2:0]  ii  [2];
    logic [2:0]  di  [2];
    logic        fl  [2];
    logic        sw  [2];
    logic        pw  [2];
    logic        h   [2];
    logic        he  [2];
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;

  // reference state
  logic [63:0] m_msr[2];
  logic [31:0] m_base[2];
  logic        m_halt[2];

  task automatic chk(input string tag, input string what, input int inst,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s inst%0d actual=%h expected=%h", tag, what, inst, act, expv);
    end
  endtask

  function automatic exp_t make_exp(input string tag);
    exp_t e;
    e.tag = tag;
    for (int k = 0; k < 2; k++) begin
      e.msr[k]  = m_msr[k];
      e.base[k] = m_base[k];
      e.h[k]    = m_halt[k];
      e.hf[k]   = (m_msr[k] & HM) | nmsr_flags;
      if (k == 0) begin
        e.ii[k] = {m_msr[k][60], ~m_msr[k][5], ~m_msr[k][14]};
        e.di[k] = {m_msr[k][60], ~m_msr[k][4], ~m_msr[k][14]};
      end else begin
        e.ii[k] = {m_msr[k][28], m_msr[k][5], ~m_msr[k][14]};
        e.di[k] = {m_msr[k][28], m_msr[k][4], ~m_msr[k][14]};
      end
      e.fl[k] = 1'b0; e.sw[k] = 1'b0; e.pw[k] = 1'b0; e.he[k] = 1'b0;
    end
    return e;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    for (int k = 0; k < 2; k++) begin
      m_msr[k] = RSTV; m_base[k] = RSTV[6] ? 32'hFFF0_0000 : 32'h0; m_halt[k] = 1'b0;
    end
    begin
      exp_t e;
      e = make_exp("R1");
      for (int k = 0; k < 2; k++) e.hf[k] = RSTV & HM;
      exp_q.push_back(e);
    end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(input logic irq, input logic [63:0] junk, input string tag);
    @(negedge clk);
    wr_valid = 1'b0;
    wr_data = junk;
    irq_pending = irq;
    @(posedge clk);
    #1;
    for (int k = 0; k < 2; k++) if (irq) m_halt[k] = 1'b0;
    exp_q.push_back(make_exp(tag));
  endtask

  task automatic wr(input logic [63:0] v, input logic alter, input logic irq,
                    input logic pok, input logic [63:0] nm, input string tag);
    exp_t e;
    logic [63:0] c, n;
    logic fl[2], sw[2], pw[2], he[2];
    @(negedge clk);
    wr_valid = 1'b1; wr_data = v; wr_alter_hv = alter;
    irq_pending = irq; pow_ok = pok; nmsr_flags = nm;
    @(posedge clk);
    #1;
    for (int k = 0; k < 2; k++) begin
      c = m_msr[k];
      n = v & WM;
      if (!(alter && c[60])) n[60] = c[60];
      if (k == 0 && n[14]) begin n[15] = 1'b1; n[5] = 1'b1; n[4] = 1'b1; end
      fl[k] = (n[5] ^ c[5]) | (n[4] ^ c[4]) | ((k == 1) && (n[28] ^ c[28]));
      sw[k] = (k == 0) && (n[17] ^ c[17]);
      pw[k] = n[6] ^ c[6];
      he[k] = n[18] && !irq && pok;
      if (pw[k]) m_base[k] = n[6] ? 32'hFFF0_0000 : 32'h0;
      if (he[k]) m_halt[k] = 1'b1;
      else if (irq) m_halt[k] = 1'b0;
      m_msr[k] = n;
    end
    e = make_exp(tag);
    for (int k = 0; k < 2; k++) begin
      e.fl[k] = fl[k]; e.sw[k] = sw[k]; e.pw[k] = pw[k]; e.he[k] = he[k];
    end
    exp_q.push_back(e);
    idle(1'b0, ~v, {tag, " R13 R14 idle"});
  endtask

  // monitor: compare each expected item at the falling edge after it was pushed
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      for (int k = 0; k < 2; k++) begin
        chk(e.tag, "msr", k, o_msr[k], e.msr[k]);
        chk(e.tag, "hflags R10", k, o_hf[k], e.hf[k]);
        chk(e.tag, "base R7", k, 64'(o_base[k]), 64'(e.base[k]));
        chk(e.tag, "immu R8 R9", k, 64'(o_ii[k]), 64'(e.ii[k]));
        chk(e.tag, "dmmu R8 R9", k, 64'(o_di[k]), 64'(e.di[k]));
        chk(e.tag, "flush R5", k, 64'(o_fl[k]), 64'(e.fl[k]));
        chk(e.tag, "swap R6", k, 64'(o_sw[k]), 64'(e.sw[k]));
        chk(e.tag, "prefix R7", k, 64'(o_pw[k]), 64'(e.pw[k]));
        chk(e.tag, "halt R11 R12", k, 64'(o_h[k]), 64'(e.h[k]));
        chk(e.tag, "halt_evt R11", k, 64'(o_he[k]), 64'(e.he[k]));
        chk(e.tag, "ready R14", k, 64'(rdy[k]), 64'd1);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R2: unwritable bits 1,2 dropped; relocate bits change -> flush
    wr(64'h9000_0000_0000_0036, 1'b0, 1'b0, 1'b0, '0, "R2 R5");
    // R3: unprivileged clear of HV has no effect
    wr(64'h8000_0000_0000_0030, 1'b0, 1'b0, 1'b0, '0, "R3 keep");
    // R3: privileged clear while set takes effect
    wr(64'h8000_0000_0000_0030, 1'b1, 1'b0, 1'b0, '0, "R3 clear");
    // R3: privileged set while clear is refused
    wr(64'h9000_0000_0000_0030, 1'b1, 1'b0, 1'b0, '0, "R3 refuse");
    // R4 R8 R9: problem state with enables off
    wr(64'h8000_0000_0000_4000, 1'b0, 1'b0, 1'b0, '0, "R4 R8 R9");
    wr(64'h8000_0000_0000_0010, 1'b0, 1'b0, 1'b0, '0, "R8 R9 mixed");
    wr(64'h8000_0000_0000_0020, 1'b0, 1'b0, 1'b0, '0, "R8 R9 swap sides");
    // R6: shadow toggle
    wr(64'h8000_0000_0002_0020, 1'b0, 1'b0, 1'b0, '0, "R6 on");
    wr(64'h8000_0000_0000_0020, 1'b0, 1'b0, 1'b0, '0, "R6 off");
    // R7: prefix set then clear
    wr(64'h8000_0000_0000_0060, 1'b0, 1'b0, 1'b0, '0, "R7 high");
    wr(64'h8000_0000_0000_0060, 1'b0, 1'b0, 1'b0, '0, "R7 same");
    wr(64'h8000_0000_0000_0020, 1'b0, 1'b0, 1'b0, '0, "R7 low");
    // R5: guest-state alone flushes only embedded
    wr(64'h8000_0000_1000_0020, 1'b0, 1'b0, 1'b0, '0, "R5 R9 gs");
    // R10: excluded bits 11/8 and merged flags
    wr(64'h8000_0000_1000_2B21, 1'b0, 1'b0, 1'b0, 64'h0000_0000_0000_0800, "R10");
    // R11: power-save refused by pending interrupt, then by pow_ok low
    wr(64'h8000_0000_1004_0020, 1'b0, 1'b1, 1'b1, '0, "R11 irq");
    wr(64'h8000_0000_1004_0020, 1'b0, 1'b0, 1'b0, '0, "R11 no perm");
    // R11: halt entered
    wr(64'h8000_0000_1004_0020, 1'b0, 1'b0, 1'b1, '0, "R11 enter");
    idle(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, "R11 R14 stay");
    // R12: interrupt wakes
    idle(1'b1, 64'h0, "R12 wake");
    idle(1'b0, 64'h0, "R12 after");
    // R1: reset mid-run
    wr(64'h8000_0000_0000_4040, 1'b0, 1'b0, 1'b1, '0, "pre R1");
    do_reset();
    idle(1'b0, 64'h1234, "R1 R14 post");
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule